// File: doc/BRIEF.md
# Shared Read-Only Instruction Cache

This block sits between the instruction fetchers of several cores and one external program memory. A fetcher asks for an instruction by raising its fetch-valid line and driving its program counter. The cache picks one waiting fetcher per cycle in rotating order and looks the address up in a direct-mapped store. Each entry of the store holds a valid flag, a tag and one 16-bit instruction.

On a hit, the instruction goes back to that fetcher on the next clock edge, and external memory is not touched. On a miss, the cache issues a single read to program memory and holds it until memory answers. It then writes the returned word into the entry and hands the word to the fetcher. Each fetcher has its own ready flag and instruction lane. The flag tells the fetcher that it may move on to decode.

The cache never writes to program memory. Only one memory read is in flight at a time. While a miss is outstanding, no other fetcher is served.

Top module: `fetch_icache`

## Requirements
- R1: Reset clears every valid flag, every ready flag and the memory read strobe, so the first fetch of any address after reset goes to external memory.
- R2: A fetch that hits raises that core's ready flag on the first clock edge after the request is granted, and no memory read is issued.
- R3: A fetch that misses raises memReadValid with memReadAddr equal to the program counter. Both stay unchanged until memReadReady is seen. On that edge the word on memReadData is delivered to the fetcher as its instruction.
- R4: After a miss has been serviced, a later fetch of the same address hits.
- R5: The entry index is the low log2(LINES) bits of the address, and the remaining upper bits are the tag. A miss to an address with the same index and a different tag replaces the entry, so the evicted address misses again.
- R6: A core's ready flag stays high for as long as its fetch-valid stays high. It clears on the first edge at which fetch-valid is seen low.
- R7: Among fetchers that are requesting and not yet ready, the grant goes to the first one found by searching upward, with wrap-around, from the core after the one granted last. After reset the search starts at core 0.
- R8: At most one memory read is outstanding. While a miss is pending, no other fetcher is granted, including one whose address would hit.
- R9: Each delivery raises the ready flag of exactly one core, the one that was granted. The word appears on that core's lane, bits [16*c+15:16*c].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | NUM_CORES | Per-core fetch request |
| fetchAddr | input | NUM_CORES*ADDR_W | Per-core program counter; core c at bits [ADDR_W*c +: ADDR_W] |
| fetchReady | output | NUM_CORES | Per-core delivery flag |
| fetchInstr | output | NUM_CORES*INSTR_W | Per-core delivered instruction |
| memReadValid | output | 1 | Read request to program memory |
| memReadAddr | output | ADDR_W | Read address to program memory |
| memReadReady | input | 1 | Memory answer strobe; data valid in the same cycle |
| memReadData | input | INSTR_W | Instruction word returned by memory |

## Verification
Two events can land on the same edge: a miss completing and installing its word for one core, and the ready flag of a different core clearing because that core dropped its fetch-valid. The bench arranges this case. Core 0 first takes a hit while core 1's miss is queued behind it. Core 0 then holds its request for exactly two cycles, so that it drops its request at the same moment memory answers core 1. The case passes if core 1 receives the memory word and core 0's flag is low on the same edge, with no stray delivery on either lane.

// File: rtl/fetch_icache_pkg.sv
package fetch_icache_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic latchMiss;   // capture the granted address as the pending miss
    logic install;     // write memReadData into the pending miss entry
    logic deliverHit;  // hand the stored word to the granted core
    logic deliverMem;  // hand the memory word to the granted core
  } cacheCtl_t;
endpackage

// File: rtl/fetch_icache_rrarb.sv
module fetch_icache_rrarb #(
  parameter int NUM_CORES = 3,
  localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic [NUM_CORES-1:0] req,
  input  logic [SEL_W-1:0]     lastGrant,
  output logic                 anyReq,
  output logic [SEL_W-1:0]     pick
);
  always_comb begin
    anyReq = 1'b0;
    pick   = lastGrant;
    for (int k = 1; k <= NUM_CORES; k++) begin
      int cand;
      cand = int'(lastGrant) + k;
      if (cand >= NUM_CORES) cand = cand - NUM_CORES;
      if (!anyReq && req[cand]) begin
        anyReq = 1'b1;
        pick   = SEL_W'(cand);
      end
    end
  end
endmodule

// File: rtl/fetch_icache_ctrl.sv
module fetch_icache_ctrl
  import fetch_icache_pkg::*;
#(
  parameter int NUM_CORES = 3,
  localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CORES-1:0] fetchValid,
  input  logic [NUM_CORES-1:0] fetchReady,
  input  logic                 lookupHit,
  input  logic                 memReadReady,
  output logic [SEL_W-1:0]     selCore,
  output cacheCtl_t            ctl,
  output logic                 memReadValid
);
  typedef enum logic {IDLE, MISS} state_t;

  state_t            stateQ;
  logic [SEL_W-1:0]  lastQ, grantQ, pick;
  logic              anyReq;
  logic [NUM_CORES-1:0] pending;

  assign pending = fetchValid & ~fetchReady;

  fetch_icache_rrarb #(.NUM_CORES(NUM_CORES)) u_arb (
    .req(pending), .lastGrant(lastQ), .anyReq(anyReq), .pick(pick)
  );

  assign selCore      = (stateQ == MISS) ? grantQ : pick;
  assign memReadValid = (stateQ == MISS);

  always_comb begin
    ctl = '0;
    if (stateQ == IDLE) begin
      if (anyReq) begin
        ctl.deliverHit = lookupHit;
        ctl.latchMiss  = !lookupHit;
      end
    end else if (memReadReady) begin
      ctl.install    = 1'b1;
      ctl.deliverMem = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= IDLE;
      lastQ  <= SEL_W'(NUM_CORES - 1);
      grantQ <= '0;
    end else if (stateQ == IDLE) begin
      if (anyReq) begin
        lastQ <= pick;
        if (!lookupHit) begin
          stateQ <= MISS;
          grantQ <= pick;
        end
      end
    end else if (memReadReady) begin
      stateQ <= IDLE;
    end
  end
endmodule

// File: rtl/fetch_icache_dpath.sv
module fetch_icache_dpath
  import fetch_icache_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 8,
  parameter int INSTR_W   = 16,
  parameter int LINES     = 8,
  localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int IDX_W = $clog2(LINES),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CORES-1:0]         fetchValid,
  input  logic [NUM_CORES*ADDR_W-1:0]  fetchAddr,
  input  logic [SEL_W-1:0]             selCore,
  input  cacheCtl_t                    ctl,
  input  logic [INSTR_W-1:0]           memReadData,
  output logic                         lookupHit,
  output logic [ADDR_W-1:0]            missAddr,
  output logic [NUM_CORES-1:0]         fetchReady,
  output logic [NUM_CORES*INSTR_W-1:0] fetchInstr
);
  logic [LINES-1:0]   validQ;
  logic [TAG_W-1:0]   tagQ  [LINES];
  logic [INSTR_W-1:0] dataQ [LINES];
  logic [ADDR_W-1:0]  reqAddr, missAddrQ;
  logic [IDX_W-1:0]   reqIdx, missIdx;
  logic [INSTR_W-1:0] deliverWord;
  logic               deliver;

  assign reqAddr   = fetchAddr[selCore*ADDR_W +: ADDR_W];
  assign reqIdx    = reqAddr[IDX_W-1:0];
  assign missIdx   = missAddrQ[IDX_W-1:0];
  assign lookupHit = validQ[reqIdx] && (tagQ[reqIdx] == reqAddr[ADDR_W-1:IDX_W]);
  assign missAddr  = missAddrQ;
  assign deliver   = ctl.deliverHit | ctl.deliverMem;
  assign deliverWord = ctl.deliverMem ? memReadData : dataQ[reqIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ    <= '0;
      missAddrQ <= '0;
    end else begin
      if (ctl.install)   validQ[missIdx] <= 1'b1;
      if (ctl.latchMiss) missAddrQ <= reqAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.install) begin
      tagQ[missIdx]  <= missAddrQ[ADDR_W-1:IDX_W];
      dataQ[missIdx] <= memReadData;
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_lane
    logic               laneReadyQ;
    logic [INSTR_W-1:0] laneInstrQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneReadyQ <= 1'b0;
        laneInstrQ <= '0;
      end else if (deliver && (selCore == SEL_W'(c))) begin
        laneReadyQ <= 1'b1;
        laneInstrQ <= deliverWord;
      end else if (!fetchValid[c]) begin
        laneReadyQ <= 1'b0;
      end
    end
    assign fetchReady[c] = laneReadyQ;
    assign fetchInstr[c*INSTR_W +: INSTR_W] = laneInstrQ;
  end
endmodule

// File: rtl/fetch_icache.sv
module fetch_icache
  import fetch_icache_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 8,
  parameter int INSTR_W   = 16,
  parameter int LINES     = 8,
  localparam int SEL_W = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [NUM_CORES-1:0]         fetchValid,
  input  logic [NUM_CORES*ADDR_W-1:0]  fetchAddr,
  output logic [NUM_CORES-1:0]         fetchReady,
  output logic [NUM_CORES*INSTR_W-1:0] fetchInstr,
  output logic                         memReadValid,
  output logic [ADDR_W-1:0]            memReadAddr,
  input  logic                         memReadReady,
  input  logic [INSTR_W-1:0]           memReadData
);
  cacheCtl_t        ctl;
  logic [SEL_W-1:0] selCore;
  logic             lookupHit;

  fetch_icache_ctrl #(.NUM_CORES(NUM_CORES)) u_ctrl (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchReady(fetchReady),
    .lookupHit(lookupHit), .memReadReady(memReadReady), .selCore(selCore),
    .ctl(ctl), .memReadValid(memReadValid)
  );

  fetch_icache_dpath #(
    .NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .INSTR_W(INSTR_W), .LINES(LINES)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .selCore(selCore), .ctl(ctl), .memReadData(memReadData),
    .lookupHit(lookupHit), .missAddr(memReadAddr),
    .fetchReady(fetchReady), .fetchInstr(fetchInstr)
  );
endmodule

// File: rtl/fetch_icache_chk.sv
module fetch_icache_chk #(
  parameter int NUM_CORES = 3,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CORES-1:0] fetchValid,
  input logic [NUM_CORES-1:0] fetchReady,
  input logic                 memReadValid,
  input logic [ADDR_W-1:0]    memReadAddr,
  input logic                 memReadReady
);
  logic [NUM_CORES-1:0] prevReady;
  logic [NUM_CORES-1:0] newReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevReady <= '0;
    else       prevReady <= fetchReady;
  end
  assign newReady = fetchReady & ~prevReady;

  // R3
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReadValid && !memReadReady |=> memReadValid && $stable(memReadAddr));

  // R3
  miss_delivers_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReadValid && memReadReady |=> (newReady != '0));

  // R8
  single_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReadValid && memReadReady |=> !memReadValid);

  // R9
  one_delivery_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(newReady) <= 1);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    // R6
    ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      fetchReady[c] && fetchValid[c] |=> fetchReady[c]);
    // R6
    ready_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      fetchReady[c] && !fetchValid[c] |=> !fetchReady[c]);
    // R9
    ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rstN)
      !fetchReady[c] && !fetchValid[c] |=> !fetchReady[c]);
  end
endmodule

bind fetch_icache fetch_icache_chk #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchReady(fetchReady),
  .memReadValid(memReadValid), .memReadAddr(memReadAddr), .memReadReady(memReadReady)
);

// File: tb/fetch_icache_bench.sv
module fetch_icache_bench;
  localparam int NC = 3;
  localparam int AW = 8;
  localparam int IW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NC-1:0]    fetchValid = '0;
  logic [NC*AW-1:0] fetchAddr  = '0;
  logic [NC-1:0]    fetchReady;
  logic [NC*IW-1:0] fetchInstr;
  logic             memReadValid;
  logic [AW-1:0]    memReadAddr;
  logic             memReadReady = 1'b0;
  logic [IW-1:0]    memReadData  = '0;

  always #10 clk = ~clk;

  fetch_icache #(.NUM_CORES(NC), .ADDR_W(AW), .INSTR_W(IW), .LINES(8)) u_fetch_icache (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchAddr(fetchAddr),
    .fetchReady(fetchReady), .fetchInstr(fetchInstr), .memReadValid(memReadValid),
    .memReadAddr(memReadAddr), .memReadReady(memReadReady), .memReadData(memReadData)
  );

  int checks = 0;
  int fails = 0;
  int memReads = 0;
  int memWait = 0;

  typedef struct { int core; logic [IW-1:0] instr; } exp_t;
  exp_t expQ[$];
  int grantLog[$];
  logic [NC-1:0] prevR = '0;

  function automatic logic [IW-1:0] memWord(logic [AW-1:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // program memory model: answers two cycles after a request is seen
  always @(negedge clk) begin
    if (!rstN) begin
      memReadReady = 1'b0;
      memWait = 0;
    end else if (memReadReady) begin
      memReadReady = 1'b0;
      memWait = 0;
    end else if (memReadValid) begin
      memWait++;
      if (memWait == 2) begin
        memReadReady = 1'b1;
        memReadData  = memWord(memReadAddr);
        memReads++;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < NC; c++) begin
        if (fetchReady[c] && !prevR[c]) begin
          int hit;
          hit = -1;
          grantLog.push_back(c);
          for (int i = 0; i < expQ.size(); i++)
            if (hit < 0 && expQ[i].core == c) hit = i;
          if (hit < 0) begin
            check(1'b0, "R9", "unexpected delivery on core", c, -1);
          end else begin
            check(fetchInstr[c*IW +: IW] == expQ[hit].instr, "R9", "lane instruction",
                  int'(fetchInstr[c*IW +: IW]), int'(expQ[hit].instr));
            expQ.delete(hit);
          end
        end
      end
    end
    prevR = fetchReady;
  end

  task automatic doReq(int c, logic [AW-1:0] a, int expLat, int hold, string tag);
    int lat;
    expQ.push_back('{c, memWord(a)});
    @(negedge clk);
    fetchValid[c] = 1'b1;
    fetchAddr[c*AW +: AW] = a;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!fetchReady[c] && lat < 50);
    if (expLat > 0) check(lat == expLat, tag, "latency", lat, expLat);
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      check(fetchReady[c] == 1'b1, "R6", "ready held", int'(fetchReady[c]), 1);
    end
    fetchValid[c] = 1'b0;
    @(negedge clk);
    check(fetchReady[c] == 1'b0, "R6", "ready cleared", int'(fetchReady[c]), 0);
  endtask

  task automatic finishRun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

  initial begin
    int m0;
    repeat (4) @(negedge clk);
    // R1 reset state
    check(fetchReady == '0, "R1", "ready after reset", int'(fetchReady), 0);
    check(memReadValid == 1'b0, "R1", "mem strobe after reset", int'(memReadValid), 0);
    rstN = 1'b1;

    // R1 / R3 cold miss
    m0 = memReads;
    doReq(0, 8'h05, 3, 1, "R3");
    check(memReads - m0 == 1, "R1", "cold fetch reads memory", memReads - m0, 1);

    // R2 / R4 hit after install, also from another core
    m0 = memReads;
    doReq(0, 8'h05, 1, 1, "R2");
    doReq(2, 8'h05, 1, 2, "R2");
    check(memReads == m0, "R4", "no memory read on hit", memReads - m0, 0);

    // R5 conflict eviction: 0x15 shares index 5 with 0x05
    m0 = memReads;
    doReq(1, 8'h15, 3, 1, "R5");
    doReq(0, 8'h05, 3, 1, "R5");
    check(memReads - m0 == 2, "R5", "evicted line refetched", memReads - m0, 2);

    // warm lines, last grant ends on core 1
    doReq(0, 8'h06, 3, 1, "R3");
    doReq(2, 8'h07, 3, 1, "R3");
    doReq(1, 8'h03, 3, 1, "R3");

    // R7 round robin, last grant = core 1 -> order 2,0,1
    grantLog.delete();
    m0 = memReads;
    fork
      doReq(0, 8'h06, -1, 1, "R7");
      doReq(1, 8'h03, -1, 1, "R7");
      doReq(2, 8'h07, -1, 1, "R7");
    join
    check(grantLog.size() == 3, "R7", "grant count", grantLog.size(), 3);
    if (grantLog.size() == 3) begin
      check(grantLog[0] == 2, "R7", "first grant", grantLog[0], 2);
      check(grantLog[1] == 0, "R7", "second grant", grantLog[1], 0);
      check(grantLog[2] == 1, "R7", "third grant", grantLog[2], 1);
    end
    check(memReads == m0, "R2", "all-hit round reads memory", memReads - m0, 0);

    // R7 second round, last grant = core 1, requests on 1 and 2 -> 2 first
    grantLog.delete();
    fork
      doReq(1, 8'h03, -1, 1, "R7");
      doReq(2, 8'h07, -1, 1, "R7");
    join
    check(grantLog.size() == 2 && grantLog[0] == 2, "R7", "wrap-around grant",
          (grantLog.size() > 0) ? grantLog[0] : -1, 2);

    // R8 a hit waits behind an outstanding miss
    m0 = memReads;
    fork
      doReq(0, 8'h31, 3, 1, "R8");
      begin @(negedge clk); doReq(1, 8'h03, 3, 1, "R8"); end
    join
    check(memReads - m0 == 1, "R8", "single memory read", memReads - m0, 1);

    // same-edge: miss delivery to core 1 while core 0 ready clears
    fork
      doReq(0, 8'h05, 1, 2, "R6");
      doReq(1, 8'h42, 4, 1, "R3");
    join
    m0 = memReads;
    doReq(1, 8'h42, 1, 1, "R4");
    check(memReads == m0, "R4", "installed word hits", memReads - m0, 0);

    repeat (2) @(negedge clk);
    check(expQ.size() == 0, "R9", "every fetch delivered", expQ.size(), 0);
    finishRun();
  end
endmodule